// File: doc/BRIEF.md
# Split-Mode Latched Event Counter Bank

This block holds a bank of physical event counters that software reaches through a 64-bit memory-mapped bus. Each physical counter runs as one full-width counter, or it splits into two independent half-width counters. One size bit per physical counter in a global control word selects the mode. Event inputs drive the counting, one per logical counter, and an overflow output pulses when a logical counter wraps.

A bus write to a counter does not touch the running value. The data goes into a holding latch and the counter is marked pending. The held value reaches the live counter only when software writes the control word with the global enable bit set. If the bank is already enabled, software rewrites the control word with enable still set to commit pending values. Clearing the enable bit freezes every counter at its current value.

Registers are 32 bits wide and sit in the upper half of the 64-bit bus word. Word address 0 is the control word. Word addresses with the top address bit set select physical counter `addr[2:0]`. Every other address is unmapped.

Top module: `split_event_counter_bank`

## Requirements
- R1: After reset, the control word reads 0, every counter reads 0 and `ovf_o` is all zero.
- R2: A write to address 0 stores bit 31 of the register (wdata bit 63) as the global enable and register bits [7:0] (wdata bits [39:32]) as the per-counter size bits, where 1 selects split mode. A read of address 0 returns `{enable, 23'b0, size[7:0]}` in bits [63:32], with bits [31:0] zero. All other register bits are discarded.
- R3: A write to a counter address loads only that counter's holding latch and marks it pending. A read still returns the live value, and the live value keeps counting while enabled.
- R4: A control write with enable=1 loads every pending counter from its latch and clears its pending flag. This applies on the first enable and on each later re-enable write. Counters with no pending write are not reloaded.
- R5: In full mode, while enabled, physical counter p adds one on each cycle where `ev_i[p]` is high. `ev_i[p+8]` has no effect.
- R6: In split mode, the upper 16 bits of counter p count `ev_i[p]` (logical counter p). The lower 16 bits count `ev_i[p+8]` (logical counter p+8).
- R7: In split mode, a wrap of the lower half from 0xFFFF to 0 does not carry into the upper half.
- R8: In full mode, a counter at 0xFFFFFFFF that takes an event becomes 0. `ovf_o[p]` is then high for exactly the one cycle in which the counter reads 0.
- R9: In split mode, a wrapping upper half pulses `ovf_o[p]` and a wrapping lower half pulses `ovf_o[p+8]`. Each pulse lasts one cycle and comes in the cycle in which that half reads 0.
- R10: With the global enable clear, counters hold their values whatever the event inputs do.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe, one write per cycle |
| addr_i | input | 4 | Word address |
| wdata_i | input | 64 | Write data; register value in [63:32] |
| rdata_o | output | 64 | Read data for `addr_i`, register in [63:32], [31:0] zero |
| ev_i | input | 16 | Event inputs, one per logical counter |
| ovf_o | output | 16 | One-cycle overflow pulses, one per logical counter |

## Verification
The in-line assertions check these properties on every cycle:
- a counter write only fills the latch;
- a commit loads exactly the latched value and clears the pending flag;
- a frozen counter does not move;
- in split mode, the upper half never changes without its own event;
- an overflow flag is raised only when its half reads zero;
- the control word changes only on a write to address 0.

Some behaviour only the bench scenarios can show:
- re-enable commits while the bank is counting;
- a commit leaves counters with no pending write untouched;
- the exact cycle and the single-cycle width of the overflow pulses;
- the use of the upper bus half for data.

// File: rtl/ecb_pkg.sv
// Shared types for the split-mode event counter bank.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package ecb_pkg;
    // Address region picked by the bus decoder.
    typedef enum logic [1:0] {
        RG_CTRL = 2'd0,
        RG_CNT  = 2'd1,
        RG_NONE = 2'd2
    } ecb_region_e;
endpackage

// File: rtl/ecb_ctrl_reg.sv
// Bus decoder and global control word for the counter bank.
// It holds the enable bit and the per-counter size bits, raises commit on
// a control write with enable set, and produces one-hot counter write strobes.
// Assumes: at most one bus write per cycle, and CNT_W-1 > NUM_PHYS.
module ecb_ctrl_reg
    import ecb_pkg::*;
#(
    parameter int NUM_PHYS = 8,
    parameter int CNT_W    = 32,
    parameter int BUS_W    = 64,
    localparam int IDX_W   = $clog2(NUM_PHYS),
    localparam int ADDR_W  = IDX_W + 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [BUS_W-1:0]    wdata_i,
    output logic                en_o,
    output logic [NUM_PHYS-1:0] size_o,
    output logic                commit_o,
    output logic [NUM_PHYS-1:0] ctr_wr_o,
    output ecb_region_e         region_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic [CNT_W-1:0]    ctrl_word_o
);
    logic [CNT_W-1:0] wr_word;
    logic             ctrl_wr;

    assign wr_word = wdata_i[BUS_W-1 -: CNT_W];
    assign idx_o   = addr_i[IDX_W-1:0];

    // Map the word address onto a register region.
    always_comb begin
        if (addr_i[ADDR_W-1])        region_o = RG_CNT;
        else if (idx_o == '0)        region_o = RG_CTRL;
        else                         region_o = RG_NONE;
    end

    assign ctrl_wr  = wr_en_i && (region_o == RG_CTRL);
    assign commit_o = ctrl_wr && wr_word[CNT_W-1];

    // One write strobe per physical counter.
    for (genvar i = 0; i < NUM_PHYS; i++) begin : g_wr
        assign ctr_wr_o[i] = wr_en_i && (region_o == RG_CNT) && (idx_o == IDX_W'(i));
    end

    // Control word register: enable bit and size bits.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_o   <= 1'b0;
            size_o <= '0;
        end else if (ctrl_wr) begin
            en_o   <= wr_word[CNT_W-1];
            size_o <= wr_word[NUM_PHYS-1:0];
        end
    end

    assign ctrl_word_o = {en_o, {(CNT_W-1-NUM_PHYS){1'b0}}, size_o};

    // R2
    ctrl_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_wr |=> (en_o == $past(wr_word[CNT_W-1])) &&
                    (size_o == $past(wr_word[NUM_PHYS-1:0])));

    // R11
    ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_wr |=> $stable(en_o) && $stable(size_o));
endmodule

// File: rtl/ecb_slice.sv
// One physical counter with its holding latch and pending flag.
// In full mode the whole word counts ev_hi_i. In split mode the upper half
// counts ev_hi_i and the lower half counts ev_lo_i, with no carry between them.
// A commit with a pending latch value overrides counting in that cycle.
// Assumes: wr_i and commit_i are never high together, and CNT_W is even.
module ecb_slice #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             split_i,
    input  logic             commit_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             ev_hi_i,
    input  logic             ev_lo_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_hi_o,
    output logic             ovf_lo_o
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0]  cnt_q, cnt_d, latch_q;
    logic [HALF_W-1:0] hi_q, lo_q;
    logic              pend_q, load, ovf_hi_d, ovf_lo_d;

    assign hi_q  = cnt_q[CNT_W-1:HALF_W];
    assign lo_q  = cnt_q[HALF_W-1:0];
    assign load  = commit_i && pend_q;
    assign cnt_o = cnt_q;

    // Next counter value and wrap detection.
    always_comb begin
        cnt_d    = cnt_q;
        ovf_hi_d = 1'b0;
        ovf_lo_d = 1'b0;
        if (load) begin
            cnt_d = latch_q;
        end else if (en_i) begin
            if (split_i) begin
                cnt_d    = {hi_q + HALF_W'(ev_hi_i), lo_q + HALF_W'(ev_lo_i)};
                ovf_hi_d = ev_hi_i && (&hi_q);
                ovf_lo_d = ev_lo_i && (&lo_q);
            end else begin
                cnt_d    = cnt_q + CNT_W'(ev_hi_i);
                ovf_hi_d = ev_hi_i && (&cnt_q);
            end
        end
    end

    // Counter and overflow pulse registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q    <= '0;
            ovf_hi_o <= 1'b0;
            ovf_lo_o <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            ovf_hi_o <= ovf_hi_d;
            ovf_lo_o <= ovf_lo_d;
        end
    end

    // Holding latch and pending flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            latch_q <= '0;
            pend_q  <= 1'b0;
        end else if (wr_i) begin
            latch_q <= wdata_i;
            pend_q  <= 1'b1;
        end else if (load) begin
            pend_q  <= 1'b0;
        end
    end

    // R3
    latch_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> pend_q && (latch_q == $past(wdata_i)));

    // R3
    latch_no_touch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !en_i) |=> $stable(cnt_q));

    // R4
    commit_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load |=> (cnt_q == $past(latch_q)) && !pend_q);

    // R7
    no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (split_i && !load && !ev_hi_i) |=> $stable(hi_q));

    // R10
    frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !load) |=> $stable(cnt_q));

    // R8
    ovf_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_hi_o |-> (hi_q == '0));

    // R9
    ovf_lo_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_lo_o |-> (lo_q == '0));
endmodule

// File: rtl/split_event_counter_bank.sv
// Top of the split-mode event counter bank. It places one slice per physical
// counter, routes events and overflow pulses by logical index (upper halves
// at 0..N-1, lower halves at N..2N-1), and multiplexes the bus read word.
// Assumes: a combinational read path. The read word follows addr_i in the
// same cycle.
module split_event_counter_bank
    import ecb_pkg::*;
#(
    parameter int NUM_PHYS = 8,
    parameter int CNT_W    = 32,
    parameter int BUS_W    = 64,
    localparam int IDX_W   = $clog2(NUM_PHYS),
    localparam int ADDR_W  = IDX_W + 1,
    localparam int LOG_N   = 2 * NUM_PHYS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic [LOG_N-1:0]  ev_i,
    output logic [LOG_N-1:0]  ovf_o
);
    logic                en;
    logic [NUM_PHYS-1:0] size, ctr_wr;
    logic                commit;
    ecb_region_e         region;
    logic [IDX_W-1:0]    idx;
    logic [CNT_W-1:0]    ctrl_word;
    logic [CNT_W-1:0]    cnt_w [NUM_PHYS];
    logic [CNT_W-1:0]    rd_word;

    ecb_ctrl_reg #(
        .NUM_PHYS (NUM_PHYS),
        .CNT_W    (CNT_W),
        .BUS_W    (BUS_W)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .en_o        (en),
        .size_o      (size),
        .commit_o    (commit),
        .ctr_wr_o    (ctr_wr),
        .region_o    (region),
        .idx_o       (idx),
        .ctrl_word_o (ctrl_word)
    );

    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_slice
        ecb_slice #(.CNT_W(CNT_W)) u_slice (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .en_i     (en),
            .split_i  (size[p]),
            .commit_i (commit),
            .wr_i     (ctr_wr[p]),
            .wdata_i  (wdata_i[BUS_W-1 -: CNT_W]),
            .ev_hi_i  (ev_i[p]),
            .ev_lo_i  (ev_i[p+NUM_PHYS]),
            .cnt_o    (cnt_w[p]),
            .ovf_hi_o (ovf_o[p]),
            .ovf_lo_o (ovf_o[p+NUM_PHYS])
        );
    end

    // Select the register addressed by the bus.
    always_comb begin
        case (region)
            RG_CTRL: rd_word = ctrl_word;
            RG_CNT:  rd_word = cnt_w[idx];
            default: rd_word = '0;
        endcase
    end

    assign rdata_o = {rd_word, {(BUS_W-CNT_W){1'b0}}};

    // R11
    unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (region == RG_NONE) |-> (rdata_o == '0));
endmodule

// File: tb/split_event_counter_bank_test.sv
module split_event_counter_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [15:0] ev = '0;
    logic [15:0] ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit          is_ovf;
        logic [63:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    split_event_counter_bank uut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .ev_i    (ev),
        .ovf_o   (ovf)
    );

    // Monitor: pops one expected item per falling edge and compares it.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it  = sb.pop_front();
                act = it.is_ovf ? {48'h0, ovf} : rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s act=%h exp=%h", it.req, act, it.exp);
                end
            end
        end
    end

    // Driver tasks: each is entered at a falling edge and returns at one.
    task automatic expect_rd(input logic [3:0] a, input logic [31:0] v, input string req);
        item_t it;
        addr = a;
        it.is_ovf = 1'b0; it.exp = {v, 32'h0}; it.req = req;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_ovf(input logic [15:0] v, input string req);
        item_t it;
        it.is_ovf = 1'b1; it.exp = {48'h0, v}; it.req = req;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] v);
        wr_en = 1'b1; addr = a; wdata = {v, 32'hDEAD_BEEF};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] v, input int n);
        ev = v;
        repeat (n) @(negedge clk);
        ev = '0;
    endtask

    localparam logic [3:0] A_CTRL = 4'h0;
    function automatic logic [3:0] a_cnt(input int p);
        return 4'(8 + p);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_rd(A_CTRL, 32'h0, "R1 ctrl after reset");
        expect_rd(a_cnt(3), 32'h0, "R1 counter after reset");
        expect_ovf(16'h0, "R1 ovf after reset");

        // R3 write while disabled only fills the latch
        bus_wr(a_cnt(2), 32'h1234_5678);
        expect_rd(a_cnt(2), 32'h0, "R3 live value unchanged");
        // R4 first enable commits
        bus_wr(A_CTRL, 32'h8000_0000);
        expect_rd(a_cnt(2), 32'h1234_5678, "R4 commit on enable");
        expect_rd(A_CTRL, 32'h8000_0000, "R2 ctrl readback");

        // R5 full-mode counting, lower-half event ignored
        pulse(16'h0004, 5);
        expect_rd(a_cnt(2), 32'h1234_567D, "R5 count five events");
        pulse(16'h0400, 3);
        expect_rd(a_cnt(2), 32'h1234_567D, "R5 ev p+8 ignored in full mode");

        // R3 pending write while enabled: live keeps counting
        bus_wr(a_cnt(2), 32'h0000_0010);
        pulse(16'h0004, 2);
        expect_rd(a_cnt(2), 32'h1234_567F, "R3 live counts past pending write");
        // R4 re-enable commit, untouched non-pending counter
        bus_wr(A_CTRL, 32'h8000_0000);
        expect_rd(a_cnt(2), 32'h0000_0010, "R4 re-enable commit");
        expect_rd(a_cnt(0), 32'h0, "R4 non-pending counter untouched");
        pulse(16'h0004, 1);
        bus_wr(A_CTRL, 32'h8000_0000);
        expect_rd(a_cnt(2), 32'h0000_0011, "R4 no reload without new write");

        // R8 full-mode wrap and overflow pulse
        bus_wr(a_cnt(1), 32'hFFFF_FFFE);
        bus_wr(A_CTRL, 32'h8000_0000);
        pulse(16'h0002, 2);
        expect_ovf(16'h0002, "R8 full wrap pulse");
        expect_rd(a_cnt(1), 32'h0, "R8 wrapped to zero");
        expect_ovf(16'h0000, "R8 pulse lasts one cycle");

        // R7 R9 split-mode lower wrap without carry
        bus_wr(a_cnt(3), 32'h0005_FFFE);
        bus_wr(A_CTRL, 32'h8000_0008);
        pulse(16'h0800, 2);
        expect_ovf(16'h0800, "R9 lower half wrap pulse");
        expect_rd(a_cnt(3), 32'h0005_0000, "R7 no carry into upper half");
        // R6 halves count their own events
        pulse(16'h0008, 3);
        expect_rd(a_cnt(3), 32'h0008_0000, "R6 upper half counts ev p");
        pulse(16'h0808, 4);
        expect_rd(a_cnt(3), 32'h000C_0004, "R6 both halves count");

        // R9 upper half wrap
        bus_wr(a_cnt(3), 32'hFFFF_0000);
        bus_wr(A_CTRL, 32'h8000_0008);
        pulse(16'h0008, 1);
        expect_ovf(16'h0008, "R9 upper half wrap pulse");
        expect_rd(a_cnt(3), 32'h0, "R9 upper wrapped to zero");
        expect_ovf(16'h0000, "R9 pulse lasts one cycle");

        // R10 disable freezes counting
        bus_wr(A_CTRL, 32'h0000_0008);
        pulse(16'h0808, 3);
        expect_rd(a_cnt(3), 32'h0, "R10 split counter frozen");
        pulse(16'h0004, 2);
        expect_rd(a_cnt(2), 32'h0000_0011, "R10 full counter frozen");
        expect_rd(A_CTRL, 32'h0000_0008, "R2 enable cleared, size kept");

        // R2 undefined control bits are dropped
        bus_wr(A_CTRL, 32'h7FFF_FF00);
        expect_rd(A_CTRL, 32'h0, "R2 undefined bits read zero");

        // R11 unmapped address
        bus_wr(4'h5, 32'hFFFF_FFFF);
        expect_rd(4'h5, 32'h0, "R11 unmapped reads zero");
        expect_rd(A_CTRL, 32'h0, "R11 unmapped write ignored");
        expect_rd(a_cnt(2), 32'h0000_0011, "R11 counters unchanged");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule